// File: doc/BRIEF.md
# Compare-Match System Timer

This peripheral keeps a 64-bit free-running count and four 32-bit compare slots. The block runs on a fast system clock. The count steps by one only on cycles where a tick-enable pulse is high, and that pulse is normally a 1 MHz strobe. When a step brings the low count word to the value held in a compare slot, that slot's match flag is latched. The flag drives the slot's own active-high level interrupt line.

Software reaches the block through a flat 32-bit register port, addressed by word index. To schedule an event, software reads the low count word, adds a delay, and writes the sum into a compare slot. The sum may wrap past 2^32; it then matches after the low word wraps. To acknowledge a flag, software writes a one to that flag's bit in the status word. The reset value of the count is a parameter, so an integration can start the count close to a wrap point.

Top module: `cmp_timer`

## Requirements
- R1: After reset, status reads 0, the compare slots read 0, the count reads `RESET_COUNT` and `irq` is 0.
- R2: The count increments by exactly one on each clock edge at which `tick` is 1, and holds otherwise.
- R3: When the low word steps from 0xFFFFFFFF to 0, the high word increments by one on the same edge.
- R4: `rdata` is combinational from `idx`. Index 0 returns the flags in bits [3:0] with zeros above them. Index 1 returns count[31:0], index 2 returns count[63:32], and indices 3 to 6 return compare slots 0 to 3. Index 7 returns 0.
- R5: A write with `we` high to index 3+n loads compare slot n with `wdata`.
- R6: Flag n is set on the edge where a tick makes the low word equal to compare slot n. Loading a compare value that equals the current count does not set the flag.
- R7: `irq[n]` equals flag n. It stays high until the flag is cleared.
- R8: A write to index 0 clears each flag whose `wdata` bit is 1. A `wdata` bit of 0 leaves its flag unchanged, and writing 0xF clears all four flags.
- R9: If a match and a clear of the same flag occur on one edge, the flag ends up set.
- R10: Writes to indices 1, 2 and 7 change no register.
- R11: A compare value below the current low word, as left by a wrapped sum, matches once the low word wraps and reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| we | input | 1 | Register write strobe |
| idx | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `idx` |
| irq | output | 4 | Per-slot level interrupts |

## Verification
Two events can land on the same flag in one edge: a tick that produces a match, and a status write that clears that flag. The bench provokes this by driving `tick` together with a status write of that flag's bit. It does so on the exact cycle where the count steps onto compare slot 0. The bench model gives the match priority, and the flag must read back as set afterwards. The same run also checks the carry into the high word and a compare value that matches only after the low word wraps.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter logic [63:0] RESET_COUNT = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        we,
  input  logic [2:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  irq
);
  localparam int NCH = 4;

  logic [63:0] cnt;
  logic [31:0] cmp [NCH];
  logic [NCH-1:0] flag, hit, clr;
  logic [31:0] lo_next;

  assign lo_next = cnt[31:0] + 32'd1;
  assign clr     = (we && idx == 3'd0) ? wdata[NCH-1:0] : '0;
  assign irq     = flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= RESET_COUNT;
    else if (tick) cnt <= cnt + 64'd1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = tick && (lo_next == cmp[i]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cmp[i] <= '0;
      else if (we && idx == 3'(i + 3)) cmp[i] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | hit;

  always_comb
    case (idx)
      3'd0:    rdata = {28'd0, flag};
      3'd1:    rdata = cnt[31:0];
      3'd2:    rdata = cnt[63:32];
      3'd3:    rdata = cmp[0];
      3'd4:    rdata = cmp[1];
      3'd5:    rdata = cmp[2];
      3'd6:    rdata = cmp[3];
      default: rdata = '0;
    endcase
endmodule

// File: rtl/cmp_timer_props.sv
module cmp_timer_props (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        we,
  input logic [2:0]  idx,
  input logic [3:0]  clr_bits,
  input logic [63:0] cnt,
  input logic [3:0]  irq
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 64'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  for (genvar i = 0; i < 4; i++) begin : g_a
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !(we && idx == 3'd0 && clr_bits[i])) |=> irq[i]);

    p_rise_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(tick));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == 3'd0 && clr_bits[i] && !tick) |=> !irq[i]);
  end
endmodule

bind cmp_timer cmp_timer_props u_props (
  .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .idx(idx),
  .clr_bits(wdata[3:0]), .cnt(cnt), .irq(irq)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam logic [63:0] START = 64'h0000_0001_FFFF_FF00;

  logic clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0] idx = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0] irq;
  int total = 0, fails = 0;
  bit done = 0;

  longint unsigned m_cnt;
  int unsigned m_cmp [4];
  bit [3:0] m_flag;

  always #10 clk = ~clk;

  cmp_timer #(.RESET_COUNT(START)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .idx(idx),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = START; m_flag = 0;
      foreach (m_cmp[k]) m_cmp[k] = 0;
    end else begin
      bit [3:0] h, c;
      int unsigned nl;
      nl = int'(m_cnt[31:0]) + 1;
      h = 0;
      for (int k = 0; k < 4; k++) if (tick && nl == m_cmp[k]) h[k] = 1;
      c = (we && idx == 0) ? wdata[3:0] : 4'd0;
      m_flag = (m_flag & ~c) | h;
      if (we && idx >= 3 && idx <= 6) m_cmp[idx-3] = wdata;
      if (tick) m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] i);
    case (i)
      0: return {28'd0, m_flag};
      1: return m_cnt[31:0];
      2: return m_cnt[63:32];
      3, 4, 5, 6: return m_cmp[i-3];
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R4 model rdata", rdata, m_read(idx));
      check("R7 model irq", {28'd0, irq}, {28'd0, m_flag});
    end
  end

  task automatic step(bit t, bit w, logic [2:0] i, logic [31:0] d);
    @(negedge clk);
    tick = t; we = w; idx = i; wdata = d;
  endtask

  task automatic rd(string tag, logic [2:0] i, logic [31:0] exp);
    @(negedge clk);
    tick = 0; we = 0; idx = i; wdata = 0;
    #1 check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1 status", 0, 0);
    rd("R1 count lo", 1, 32'hFFFF_FF00);
    rd("R1 count hi", 2, 32'h1);
    rd("R1 cmp3", 6, 0);
    rd("R4 unused index", 7, 0);
    check("R1 irq", {28'd0, irq}, 0);

    step(0, 1, 3, 32'hFFFF_FF10);
    step(0, 1, 4, 32'h0000_0005);
    step(0, 1, 5, 32'hFFFF_FF03);
    step(0, 1, 6, 32'hFFFF_FF03);
    step(0, 1, 3'd1, 32'hDEAD_BEEF);
    step(0, 1, 3'd2, 32'h1234_5678);
    step(0, 1, 3'd7, 32'hFFFF_FFFF);
    rd("R5 cmp0", 3, 32'hFFFF_FF10);
    rd("R5 cmp1", 4, 32'h5);
    rd("R10 count lo", 1, 32'hFFFF_FF00);
    rd("R10 count hi", 2, 32'h1);
    step(0, 1, 4, 32'h0000_0005);
    step(0, 1, 3, 32'hFFFF_FF00);
    rd("R6 equal load no flag", 0, 0);
    step(0, 1, 3, 32'hFFFF_FF10);

    repeat (3) step(1, 0, 0, 0);
    repeat (4) step(0, 0, 0, 0);
    rd("R2 count after three ticks", 1, 32'hFFFF_FF03);
    rd("R6 flags set", 0, 32'hC);
    check("R7 irq high", {28'd0, irq}, 32'hC);

    step(0, 1, 0, 32'h4);
    step(0, 1, 0, 32'h0);
    repeat (3) step(0, 0, 0, 0);
    rd("R8 partial clear", 0, 32'h8);
    check("R7 irq held", {28'd0, irq}, 32'h8);

    repeat (12) step(1, 0, 0, 0);
    step(1, 1, 0, 32'h1);
    rd("R9 match wins over clear", 0, 32'h9);
    step(0, 1, 0, 32'hF);
    rd("R8 clear all", 0, 0);

    repeat (245) step(1, 0, 0, 0);
    rd("R3 high word carried", 2, 32'h2);
    rd("R11 low word", 1, 32'h5);
    rd("R11 wrapped compare hit", 0, 32'h2);
    check("R11 irq", {28'd0, irq}, 32'h2);

    repeat (2) step(0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule